// File: doc/BRIEF.md
# Per-Channel Flag Command Registers

This block holds two 16-channel flag words: one enables the error interrupt of each channel, and the other holds the pending interrupt request of each channel. Software changes single flags through three byte-wide, write-only command ports. It writes a channel number rather than a mask, so no read-modify-write is needed. One port sets an error-enable flag, one clears an error-enable flag, and one clears a pending request.

Each command byte is decoded into one of three operations: act on one channel, do nothing, or act on every channel. Requests are raised in hardware by a per-channel set pulse. Both flag words can be read back directly over the same simple synchronous register bus. The command ports always read as zero.

Top module: `chan_flag_cmd`

## Requirements
- R1: After reset, both flag words are zero at the outputs and at their read offsets.
- R2: A write of value v in 0..15 to the set-enable port (offset 0x1A) sets enable bit v and no other bit.
- R3: A write of value v in 0..15 to the clear-enable port (offset 0x1B) clears enable bit v and no other bit.
- R4: A write of value v in 0..15 to the clear-request port (offset 0x1C) clears request bit v and no other bit.
- R5: A command value in 16..63 leaves both flag words unchanged on every command port.
- R6: A command value in 64..127, meaning bit 6 is set, written to the set-enable port sets all 16 enable bits.
- R7: A command value in 64..127 written to a clear port zeroes that port's whole target word.
- R8: Bit 7 of a command byte is ignored, so the byte acts as its lower seven bits alone.
- R9: A read at any of the three command offsets returns zero.
- R10: A high bit of `hw_irq_set_i` sets that request bit on the next edge. It wins over a software clear of the same bit in the same cycle.
- R11: The enable word reads at offset 0x20 and the request word at offset 0x22, with bit n for channel n. A command write is visible in a read in the following cycle.
- R12: A write to any offset other than the three command ports has no effect on either flag word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| hw_irq_set_i | input | 16 | Per-channel hardware request set pulses |
| err_en_o | output | 16 | Error-interrupt enable flags |
| irq_req_o | output | 16 | Interrupt request flags |

## Verification
The command decode is driven with single-channel values at both ends of the channel range (0 and 15) and in the middle. It is also driven with the reserved band at its lower edge, middle and upper edge (16, 40, 63), and with all-channel values at 64 and 127. Together these show whether the range boundaries sit in the right place. Bytes with bit 7 set are repeated for each decode range, which tells a decoder that uses only seven bits from one that uses all eight. Hardware request pulses are applied alone, together with a single-channel clear of the same channel, and together with an all-channel clear. This separates set-wins priority from clear-wins priority and from a lost pulse.

// File: rtl/chan_flag_pkg.sv
package chan_flag_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ONE  = 2'd1,
    OP_ALL  = 2'd2
  } cmd_op_e;
endpackage

// File: rtl/chan_flag_cmd_dec.sv
module chan_flag_cmd_dec
  import chan_flag_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CMD_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int VAL_W = CMD_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [NUM_CH-1:0] mask_o
);
  logic [VAL_W-1:0] val;
  cmd_op_e          op;

  // MSB of the byte is reserved and dropped
  assign val = cmd_i[VAL_W-1:0];

  always_comb begin
    if (!valid_i)                    op = OP_NONE;
    else if (val[VAL_W-1])           op = OP_ALL;
    else if (val < VAL_W'(NUM_CH))   op = OP_ONE;
    else                             op = OP_NONE;
  end

  always_comb begin
    unique case (op)
      OP_ALL:  mask_o = '1;
      OP_ONE:  mask_o = NUM_CH'(1) << val[CH_W-1:0];
      default: mask_o = '0;
    endcase
  end

  AST_DEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> mask_o == '0);  // R12
  AST_DEC_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_o) || (&mask_o));  // R2
endmodule

// File: rtl/chan_flag_bitmap.sv
module chan_flag_bitmap #(
  parameter int NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] q_o
);
  logic [NUM_CH-1:0] q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));  // R10
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));  // R3
  AST_NO_STRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));  // R5
endmodule

// File: rtl/chan_flag_rd_mux.sv
module chan_flag_rd_mux #(
  parameter int                NUM_CH  = 16,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] ADDR_EN = 8'h20,
  parameter logic [ADDR_W-1:0] ADDR_RQ = 8'h22
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] rq_i,
  output logic [NUM_CH-1:0] rdata_o
);
  always_comb begin
    if (addr_i == ADDR_EN)      rdata_o = en_i;
    else if (addr_i == ADDR_RQ) rdata_o = rq_i;
    else                        rdata_o = '0;
  end
endmodule

// File: rtl/chan_flag_cmd.sv
module chan_flag_cmd #(
  parameter int                NUM_CH       = 16,
  parameter int                ADDR_W       = 8,
  parameter int                CMD_W        = 8,
  parameter logic [ADDR_W-1:0] ADDR_SET_EN  = 8'h1A,
  parameter logic [ADDR_W-1:0] ADDR_CLR_EN  = 8'h1B,
  parameter logic [ADDR_W-1:0] ADDR_CLR_IRQ = 8'h1C,
  parameter logic [ADDR_W-1:0] ADDR_EN_RD   = 8'h20,
  parameter logic [ADDR_W-1:0] ADDR_IRQ_RD  = 8'h22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CMD_W-1:0]  wdata_i,
  output logic [NUM_CH-1:0] rdata_o,
  input  logic [NUM_CH-1:0] hw_irq_set_i,
  output logic [NUM_CH-1:0] err_en_o,
  output logic [NUM_CH-1:0] irq_req_o
);
  localparam int NUM_CMD = 3;
  localparam int VAL_W   = CMD_W - 1;
  localparam int C_SET   = 0;
  localparam int C_CLR   = 1;
  localparam int C_CIRQ  = 2;
  localparam logic [NUM_CMD-1:0][ADDR_W-1:0] CMD_ADDR =
    {ADDR_CLR_IRQ, ADDR_CLR_EN, ADDR_SET_EN};

  logic [NUM_CMD-1:0][NUM_CH-1:0] cmd_mask;
  logic [NUM_CH-1:0]              en_q, rq_q;

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_dec
    chan_flag_cmd_dec #(.NUM_CH(NUM_CH), .CMD_W(CMD_W)) u_dec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(we_i && (addr_i == CMD_ADDR[g])),
      .cmd_i  (wdata_i),
      .mask_o (cmd_mask[g])
    );
  end

  chan_flag_bitmap #(.NUM_CH(NUM_CH)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (cmd_mask[C_SET]),
    .clr_i (cmd_mask[C_CLR]),
    .q_o   (en_q)
  );

  chan_flag_bitmap #(.NUM_CH(NUM_CH)) u_rq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (hw_irq_set_i),
    .clr_i (cmd_mask[C_CIRQ]),
    .q_o   (rq_q)
  );

  chan_flag_rd_mux #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .ADDR_EN(ADDR_EN_RD),
    .ADDR_RQ(ADDR_IRQ_RD)
  ) u_rd (
    .addr_i (addr_i),
    .en_i   (en_q),
    .rq_i   (rq_q),
    .rdata_o(rdata_o)
  );

  assign err_en_o  = en_q;
  assign irq_req_o = rq_q;

  // checks on the external view
  logic cmd_hit, rsvd_val;
  assign cmd_hit  = (addr_i == ADDR_SET_EN) || (addr_i == ADDR_CLR_EN) ||
                    (addr_i == ADDR_CLR_IRQ);
  assign rsvd_val = !wdata_i[VAL_W-1] && (wdata_i[VAL_W-1:0] >= VAL_W'(NUM_CH));

  AST_RSVD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cmd_hit && rsvd_val) |=>
      (err_en_o == $past(err_en_o)) &&
      (irq_req_o == ($past(irq_req_o) | $past(hw_irq_set_i))));  // R5
  AST_SET_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_SET_EN && wdata_i[VAL_W-1]) |=> (&err_en_o));  // R6
  AST_CLR_ALL_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_CLR_IRQ && wdata_i[VAL_W-1]) |=>
      (irq_req_o == $past(hw_irq_set_i)));  // R7
  AST_CMD_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_hit |-> (rdata_o == '0));  // R9
  AST_FOREIGN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !cmd_hit) |=> $stable(err_en_o));  // R12
endmodule

// File: tb/chan_flag_cmd_bench.sv
module chan_flag_cmd_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [15:0] rdata_o;
  logic [15:0] hw_irq_set_i = '0;
  logic [15:0] err_en_o, irq_req_o;

  localparam logic [7:0] A_SET = 8'h1A, A_CLR = 8'h1B, A_CIRQ = 8'h1C;
  localparam logic [7:0] A_EN = 8'h20, A_RQ = 8'h22;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_en = '0, exp_rq = '0;

  always #5 clk_i = ~clk_i;

  chan_flag_cmd u_chan_flag_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .hw_irq_set_i(hw_irq_set_i),
    .err_en_o(err_en_o), .irq_req_o(irq_req_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [15:0] hw = '0);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1; hw_irq_set_i = hw;
    @(negedge clk_i);
    we_i = 1'b0; hw_irq_set_i = '0; addr_i = 8'h00;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic chk_both(input string req);
    rd_chk({req, " en"}, A_EN, exp_en);
    rd_chk({req, " rq"}, A_RQ, exp_rq);
    chk({req, " err_en_o"}, err_en_o, exp_en);
    chk({req, " irq_req_o"}, irq_req_o, exp_rq);
  endtask

  task automatic t_reset;
    chk_both("R1 reset");
  endtask

  task automatic t_set_one;
    wr(A_SET, 8'd3);  exp_en = 16'h0008; chk_both("R2/R11 set ch3");
    wr(A_SET, 8'd15); exp_en = 16'h8008; chk_both("R2 set ch15");
    wr(A_SET, 8'd0);  exp_en = 16'h8009; chk_both("R2 set ch0");
  endtask

  task automatic t_clr_one;
    wr(A_CLR, 8'd15); exp_en = 16'h0009; chk_both("R3 clear ch15");
    wr(A_CLR, 8'd0);  exp_en = 16'h0008; chk_both("R3 clear ch0");
    wr(A_CLR, 8'd7);  chk_both("R3 clear unset ch7");
  endtask

  task automatic t_irq;
    wr(8'h00, 8'h00, 16'h8421); exp_rq = 16'h8421; chk_both("R10 hw set");
    wr(A_CIRQ, 8'd5);  exp_rq = 16'h8401; chk_both("R4 clear rq ch5");
    wr(A_CIRQ, 8'd15); exp_rq = 16'h0401; chk_both("R4 clear rq ch15");
  endtask

  task automatic t_reserved;
    exp_en = 16'h5a5a;
    wr(A_CLR, 8'd64);
    for (int i = 0; i < 16; i++) if (exp_en[i]) wr(A_SET, 8'(i));
    chk_both("R5 prep");
    foreach (A_LIST[k]) begin
      wr(A_LIST[k], 8'd16); chk_both("R5 value 16");
      wr(A_LIST[k], 8'd40); chk_both("R5 value 40");
      wr(A_LIST[k], 8'd63); chk_both("R5 value 63");
    end
  endtask

  localparam logic [7:0] A_LIST [3] = '{A_SET, A_CLR, A_CIRQ};

  task automatic t_all;
    wr(A_SET, 8'd64);   exp_en = 16'hffff; chk_both("R6 set all 64");
    wr(A_CLR, 8'd100);  exp_en = 16'h0000; chk_both("R7 clear en all 100");
    wr(A_SET, 8'd127);  exp_en = 16'hffff; chk_both("R6 set all 127");
    wr(A_CIRQ, 8'd64);  exp_rq = 16'h0000; chk_both("R7 clear rq all");
  endtask

  task automatic t_msb;
    wr(A_CLR, 8'hC0);   exp_en = 16'h0000; chk_both("R8 clear all msb");
    wr(A_SET, 8'h85);   exp_en = 16'h0020; chk_both("R8 set ch5 msb");
    wr(A_SET, 8'h90);   chk_both("R8 reserved msb");
    wr(A_SET, 8'hBF);   chk_both("R8 reserved 0xBF");
    wr(A_SET, 8'hFF);   exp_en = 16'hffff; chk_both("R8 set all 0xFF");
    wr(A_CLR, 8'h8E);   exp_en = 16'hbfff; chk_both("R8 clear ch14 msb");
  endtask

  task automatic t_cmd_read;
    rd_chk("R9 read set port", A_SET, 16'h0000);
    rd_chk("R9 read clr port", A_CLR, 16'h0000);
    rd_chk("R9 read cirq port", A_CIRQ, 16'h0000);
  endtask

  task automatic t_collide;
    wr(8'h00, 8'h00, 16'h0006); exp_rq = 16'h0006; chk_both("R10 prep");
    wr(A_CIRQ, 8'd2, 16'h0004); chk_both("R10 set beats clear ch2");
    wr(A_CIRQ, 8'd64, 16'h0080); exp_rq = 16'h0080; chk_both("R10 set beats clear all");
  endtask

  task automatic t_foreign;
    wr(A_EN, 8'd64);  chk_both("R12 write en offset");
    wr(A_RQ, 8'd64);  chk_both("R12 write rq offset");
    wr(8'h19, 8'd1);  chk_both("R12 write 0x19");
    wr(8'h1D, 8'd64); chk_both("R12 write 0x1D");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_set_one();
    t_clr_one();
    t_irq();
    t_reserved();
    t_all();
    t_msb();
    t_cmd_read();
    t_collide();
    t_foreign();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule